// File: doc/BRIEF.md
# Memory Operand Effective Address Generator

This block forms the 32-bit effective address of a memory operand for a register machine with eight 32-bit general registers. Up to three terms go into the address: an optional base register, an optional index register shifted left by a scale code, and a displacement that is absent or 8, 16 or 32 bits wide. Any term may be left out. The block supports displacement only, base only, base plus displacement, scaled index plus displacement, and the full base plus scaled index plus displacement form.

The whole register file arrives on one flat read port. The block picks the base and index values from that port and adds the terms in a single adder tree. The block is purely combinational. A decoder drives the select, valid and size fields, and the address is ready in the same cycle. One encoding is illegal: the stack-pointer register (register number 4) used as the index. That encoding raises a fault flag and forces the address to zero.

Top module: `ea_addr_gen`

## Requirements
- R1: `eff_addr` equals base term + index term + displacement term for every legal encoding of the inputs.
- R2: When `base_valid` is 0 the base term is zero, and `base_sel` has no effect on `eff_addr`.
- R3: When `index_valid` is 0 the index term is zero, and `index_sel` and `scale_code` have no effect. This holds even when `index_sel` is 4, in which case `addr_fault` stays 0.
- R4: `scale_code` values 2'b00, 2'b01, 2'b10 and 2'b11 multiply the index register by 1, 2, 4 and 8.
- R5: `disp_size` selects the displacement term:
  - 2'b00: no displacement. The term is zero and `disp_bits` is ignored.
  - 2'b01: bits [7:0], sign-extended.
  - 2'b10: bits [15:0], sign-extended.
  - 2'b11: all 32 bits.
  Bits above the selected width are ignored.
- R6: When `index_valid` is 1 and `index_sel` is 4, `addr_fault` is 1 and `eff_addr` is 0, whatever the other inputs are. Register 4 stays legal as a base.
- R7: The sum wraps modulo 2^32. No carry or overflow is reported.
- R8: Register k is read from bits [32k+31:32k] of `reg_file_flat`. Base and index may name the same register.
- R9: With no base, no index and no displacement, `eff_addr` is 0 and `addr_fault` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| reg_file_flat | input | 256 | Eight 32-bit general registers; register k at bits [32k+31:32k] |
| base_valid | input | 1 | Base term present |
| base_sel | input | 3 | Base register number |
| index_valid | input | 1 | Index term present |
| index_sel | input | 3 | Index register number (4 is illegal) |
| scale_code | input | 2 | Index shift amount 0..3 |
| disp_size | input | 2 | Displacement width: none, 8, 16, 32 |
| disp_bits | input | 32 | Displacement bits, low-aligned |
| eff_addr | output | 32 | Effective address, zero on fault |
| addr_fault | output | 1 | Illegal index encoding |

## Verification
Both outputs depend only on the current inputs, so they are due zero cycles after a stimulus, once the combinational paths have settled. The bench drives each vector on a rising clock edge and samples `eff_addr` and `addr_fault` at the following falling edge. A new vector is never applied before that sample is taken. The expected values come from a bench reference that multiplies the index and sign-extends the displacement through signed casts.

// File: rtl/ea_pkg.sv
// Package: shared encodings for the effective address generator.
// Assumes a 2-bit displacement size code and a 2-bit scale code.
package ea_pkg;

    typedef enum logic [1:0] {
        DISP_NONE = 2'b00,
        DISP_B8   = 2'b01,
        DISP_B16  = 2'b10,
        DISP_FULL = 2'b11
    } disp_size_e;

    localparam int SCALE_CODE_W = 2;

endpackage

// File: rtl/ea_reg_pick.sv
// Module: picks one register from a flat register read port.
// Assumes register k sits at bits [k*DATA_W +: DATA_W]. Returns zero when
// the term is not present.
module ea_reg_pick #(
    parameter int DATA_W = 32,
    parameter int NREG   = 8,
    parameter int SEL_W  = $clog2(NREG)
) (
    input  logic [NREG*DATA_W-1:0] flat,
    input  logic [SEL_W-1:0]       sel,
    input  logic                   valid,
    output logic [DATA_W-1:0]      value
);

    logic [DATA_W-1:0] regs [NREG];

    // Unpack the flat port into one slot per register.
    generate
        for (genvar k = 0; k < NREG; k++) begin : g_unpack
            assign regs[k] = flat[k*DATA_W +: DATA_W];
        end
    endgenerate

    // Select the addressed register, or zero when the term is absent.
    always_comb begin
        value = '0;
        if (valid) value = regs[sel];
    end

    // Guard: an absent term contributes nothing.
    always_comb begin
        AST_ABSENT_ZERO: assert (valid || value == '0) else $error("absent term not zero"); // R2
    end

endmodule

// File: rtl/ea_disp_ext.sv
// Module: widens the displacement to the address width.
// Assumes DATA_W >= 16. 8- and 16-bit displacements are sign-extended;
// bits above the chosen width are ignored.
module ea_disp_ext
    import ea_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [1:0]        size_code,
    input  logic [DATA_W-1:0] bits_in,
    output logic [DATA_W-1:0] ext
);

    localparam int HI8  = DATA_W - 8;
    localparam int HI16 = DATA_W - 16;

    // Decode the size code into the displacement term.
    always_comb begin
        unique case (disp_size_e'(size_code))
            DISP_NONE: ext = '0;
            DISP_B8:   ext = {{HI8{bits_in[7]}}, bits_in[7:0]};
            DISP_B16:  ext = {{HI16{bits_in[15]}}, bits_in[15:0]};
            default:   ext = bits_in;
        endcase
    end

    // Guards on the produced term against the chosen width.
    always_comb begin
        AST_DISP_NONE: assert (size_code != 2'b00 || ext == '0) else $error("disp not zero"); // R5
        AST_DISP_SEXT8: assert (size_code != 2'b01 || ($signed(ext) >= -128 && $signed(ext) <= 127)) else $error("disp8 range"); // R5
    end

endmodule

// File: rtl/ea_index_scale.sv
// Module: forms the scaled index term and detects the illegal index.
// Assumes a register value that has already been picked. The stack
// pointer slot (SP_SLOT) may not be used as the index.
module ea_index_scale #(
    parameter int DATA_W  = 32,
    parameter int SEL_W   = 3,
    parameter int SC_W    = 2,
    parameter int SP_SLOT = 4
) (
    input  logic [DATA_W-1:0] idx_value,
    input  logic              idx_valid,
    input  logic [SEL_W-1:0]  idx_sel,
    input  logic [SC_W-1:0]   scale_code,
    output logic [DATA_W-1:0] term,
    output logic              fault
);

    // Shift the index left by the scale code; zero when there is no index.
    always_comb begin
        term = '0;
        if (idx_valid) term = idx_value << scale_code;
    end

    // Flag the stack pointer slot when it is used as the index.
    always_comb begin
        fault = idx_valid && (idx_sel == SEL_W'(SP_SLOT));
    end

    // Guards: no index means no term and no fault; scaled terms have low zeros.
    always_comb begin
        AST_NO_INDEX_NO_FAULT: assert (idx_valid || (term == '0 && !fault)) else $error("idle index"); // R3
        AST_SCALE_LOW_ZERO: assert (scale_code == '0 || term[0] == 1'b0) else $error("scale low bit"); // R4
    end

endmodule

// File: rtl/ea_addr_gen.sv
// Module: top of the effective address generator.
// Sums base, scaled index and displacement modulo 2^DATA_W. Purely
// combinational. Forces the address to zero on the illegal index.
module ea_addr_gen #(
    parameter int DATA_W  = 32,
    parameter int NREG    = 8,
    parameter int SEL_W   = $clog2(NREG),
    parameter int SP_SLOT = 4
) (
    input  logic [NREG*DATA_W-1:0] reg_file_flat,
    input  logic                   base_valid,
    input  logic [SEL_W-1:0]       base_sel,
    input  logic                   index_valid,
    input  logic [SEL_W-1:0]       index_sel,
    input  logic [1:0]             scale_code,
    input  logic [1:0]             disp_size,
    input  logic [DATA_W-1:0]      disp_bits,
    output logic [DATA_W-1:0]      eff_addr,
    output logic                   addr_fault
);

    logic [DATA_W-1:0] base_term;
    logic [DATA_W-1:0] index_raw;
    logic [DATA_W-1:0] index_term;
    logic [DATA_W-1:0] disp_term;
    logic [DATA_W-1:0] sum;
    logic              idx_fault;

    ea_reg_pick #(.DATA_W(DATA_W), .NREG(NREG), .SEL_W(SEL_W)) u_base_pick (
        .flat(reg_file_flat), .sel(base_sel), .valid(base_valid), .value(base_term)
    );

    ea_reg_pick #(.DATA_W(DATA_W), .NREG(NREG), .SEL_W(SEL_W)) u_index_pick (
        .flat(reg_file_flat), .sel(index_sel), .valid(index_valid), .value(index_raw)
    );

    ea_index_scale #(.DATA_W(DATA_W), .SEL_W(SEL_W), .SC_W(2), .SP_SLOT(SP_SLOT)) u_scale (
        .idx_value(index_raw), .idx_valid(index_valid), .idx_sel(index_sel),
        .scale_code(scale_code), .term(index_term), .fault(idx_fault)
    );

    ea_disp_ext #(.DATA_W(DATA_W)) u_disp (
        .size_code(disp_size), .bits_in(disp_bits), .ext(disp_term)
    );

    // Three-input add; the carry out of the top bit is dropped.
    always_comb begin
        sum = base_term + index_term + disp_term;
    end

    // Drive the outputs; a fault overrides the sum.
    always_comb begin
        addr_fault = idx_fault;
        eff_addr   = idx_fault ? '0 : sum;
    end

    // Guards at the block edge.
    always_comb begin
        AST_FAULT_ADDR_ZERO: assert (!addr_fault || eff_addr == '0) else $error("fault addr"); // R6
        AST_FAULT_NEEDS_INDEX: assert (!addr_fault || index_valid) else $error("fault without index"); // R6
        AST_EMPTY_ZERO: assert (base_valid || index_valid || disp_size != 2'b00 || eff_addr == '0) else $error("empty form"); // R9
    end

endmodule

// File: tb/ea_addr_gen_test.sv
module ea_addr_gen_test;

    logic clk = 1'b0;
    always #4 clk = ~clk;  // 125 MHz

    logic [255:0] reg_file_flat;
    logic         base_valid, index_valid;
    logic [2:0]   base_sel, index_sel;
    logic [1:0]   scale_code, disp_size;
    logic [31:0]  disp_bits;
    logic [31:0]  eff_addr;
    logic         addr_fault;

    logic [31:0] regs [8];
    int checks = 0;
    int failures = 0;
    int cycles = 0;

    ea_addr_gen uut (
        .reg_file_flat(reg_file_flat), .base_valid(base_valid), .base_sel(base_sel),
        .index_valid(index_valid), .index_sel(index_sel), .scale_code(scale_code),
        .disp_size(disp_size), .disp_bits(disp_bits),
        .eff_addr(eff_addr), .addr_fault(addr_fault)
    );

    // Vector: {exp_fault, bv, bs[3], iv, is[3], sc[2], ds[2], disp[32]}
    localparam int NVEC = 8;
    localparam logic [44:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 3'd0, 1'b0, 3'd0, 2'd0, 2'd3, 32'h0804_A000},
        {1'b0, 1'b1, 3'd5, 1'b0, 3'd0, 2'd0, 2'd0, 32'h0000_0000},
        {1'b0, 1'b1, 3'd0, 1'b0, 3'd0, 2'd0, 2'd1, 32'h0000_00F0},
        {1'b0, 1'b0, 3'd0, 1'b1, 3'd3, 2'd2, 2'd3, 32'h0000_2000},
        {1'b0, 1'b1, 3'd7, 1'b1, 3'd5, 2'd3, 2'd2, 32'h0000_FFFC},
        {1'b0, 1'b1, 3'd6, 1'b1, 3'd6, 2'd1, 2'd1, 32'h0000_0005},
        {1'b0, 1'b1, 3'd4, 1'b1, 3'd1, 2'd0, 2'd0, 32'h0000_0000},
        {1'b1, 1'b1, 3'd0, 1'b1, 3'd4, 2'd2, 2'd3, 32'h0000_0001}
    };

    function automatic logic [31:0] ref_addr(logic bv, logic [2:0] bs, logic iv,
                                             logic [2:0] is, logic [1:0] sc,
                                             logic [1:0] ds, logic [31:0] d);
        logic [31:0] b, i, x, mul;
        b = bv ? regs[bs] : 32'd0;
        case (sc)
            2'd0: mul = 32'd1;
            2'd1: mul = 32'd2;
            2'd2: mul = 32'd4;
            default: mul = 32'd8;
        endcase
        i = iv ? regs[is] * mul : 32'd0;
        case (ds)
            2'd0: x = 32'd0;
            2'd1: x = 32'($signed(d[7:0]));
            2'd2: x = 32'($signed(d[15:0]));
            default: x = d;
        endcase
        if (iv && is == 3'd4) return 32'd0;
        return b + i + x;
    endfunction

    task automatic chk(string req, logic [31:0] a, logic [31:0] ea, logic f, logic ef);
        checks++;
        if (a !== ea || f !== ef) begin
            failures++;
            $display("FAIL %s: addr=%h fault=%b expected addr=%h fault=%b", req, a, f, ea, ef);
        end
    endtask

    // Drive one vector on a rising edge, sample at the falling edge.
    task automatic apply(logic bv, logic [2:0] bs, logic iv, logic [2:0] is,
                         logic [1:0] sc, logic [1:0] ds, logic [31:0] d);
        @(posedge clk);
        for (int k = 0; k < 8; k++) reg_file_flat[k*32 +: 32] = regs[k];
        base_valid = bv; base_sel = bs; index_valid = iv; index_sel = is;
        scale_code = sc; disp_size = ds; disp_bits = d;
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                failures++;
                $display("FAIL watchdog: cycles=%0d expected below 100000", cycles);
                $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        regs = '{32'h0000_1000, 32'h8000_0000, 32'hFFFF_FFF0, 32'h0000_0010,
                 32'h7FFF_FFFC, 32'h1234_5678, 32'hFFFF_FFFF, 32'h0040_0000};
        reg_file_flat = '0;
        base_valid = 0; base_sel = 0; index_valid = 0; index_sel = 0;
        scale_code = 0; disp_size = 0; disp_bits = 0;

        // R9: idle, empty form
        apply(0, 3'd6, 0, 3'd4, 2'd3, 2'd0, 32'hFFFF_FFFF);
        chk("R9 empty form", eff_addr, 32'd0, addr_fault, 1'b0);

        // R1: table of forms
        for (int v = 0; v < NVEC; v++) begin
            apply(VEC[v][43], VEC[v][42:40], VEC[v][39], VEC[v][38:36],
                  VEC[v][35:34], VEC[v][33:32], VEC[v][31:0]);
            chk("R1 table", eff_addr,
                ref_addr(VEC[v][43], VEC[v][42:40], VEC[v][39], VEC[v][38:36],
                         VEC[v][35:34], VEC[v][33:32], VEC[v][31:0]),
                addr_fault, VEC[v][44]);
        end

        // R2: base select ignored without base
        apply(0, 3'd1, 0, 3'd0, 2'd0, 2'd3, 32'h0000_0100);
        chk("R2 base absent", eff_addr, 32'h0000_0100, addr_fault, 1'b0);
        apply(0, 3'd6, 0, 3'd0, 2'd0, 2'd3, 32'h0000_0100);
        chk("R2 base absent other sel", eff_addr, 32'h0000_0100, addr_fault, 1'b0);

        // R3: index fields ignored without index, even select 4
        apply(1, 3'd0, 0, 3'd4, 2'd3, 2'd1, 32'h0000_0004);
        chk("R3 index absent", eff_addr, 32'h0000_1004, addr_fault, 1'b0);

        // R4: each scale code on register 3 (0x10)
        apply(0, 3'd0, 1, 3'd3, 2'd0, 2'd0, 32'd0);
        chk("R4 scale x1", eff_addr, 32'h10, addr_fault, 1'b0);
        apply(0, 3'd0, 1, 3'd3, 2'd1, 2'd0, 32'd0);
        chk("R4 scale x2", eff_addr, 32'h20, addr_fault, 1'b0);
        apply(0, 3'd0, 1, 3'd3, 2'd2, 2'd0, 32'd0);
        chk("R4 scale x4", eff_addr, 32'h40, addr_fault, 1'b0);
        apply(0, 3'd0, 1, 3'd3, 2'd3, 2'd0, 32'd0);
        chk("R4 scale x8", eff_addr, 32'h80, addr_fault, 1'b0);

        // R5: displacement widths
        apply(0, 3'd0, 0, 3'd0, 2'd0, 2'd1, 32'h1234_5680);
        chk("R5 disp8 negative", eff_addr, 32'hFFFF_FF80, addr_fault, 1'b0);
        apply(0, 3'd0, 0, 3'd0, 2'd0, 2'd2, 32'h1234_8000);
        chk("R5 disp16 negative", eff_addr, 32'hFFFF_8000, addr_fault, 1'b0);
        apply(0, 3'd0, 0, 3'd0, 2'd0, 2'd2, 32'hABCD_7FFF);
        chk("R5 disp16 positive", eff_addr, 32'h0000_7FFF, addr_fault, 1'b0);
        apply(1, 3'd0, 0, 3'd0, 2'd0, 2'd0, 32'hDEAD_BEEF);
        chk("R5 disp none ignored", eff_addr, 32'h0000_1000, addr_fault, 1'b0);

        // R6: illegal index, legal stack base
        apply(1, 3'd5, 1, 3'd4, 2'd1, 2'd3, 32'h0000_0040);
        chk("R6 fault", eff_addr, 32'd0, addr_fault, 1'b1);
        apply(1, 3'd4, 0, 3'd0, 2'd0, 2'd1, 32'h0000_0004);
        chk("R6 stack as base", eff_addr, 32'h8000_0000, addr_fault, 1'b0);

        // R7: wraparound
        apply(1, 3'd2, 0, 3'd0, 2'd0, 2'd3, 32'h0000_0020);
        chk("R7 wrap", eff_addr, 32'h0000_0010, addr_fault, 1'b0);
        apply(1, 3'd1, 1, 3'd1, 2'd0, 2'd0, 32'd0);
        chk("R7 carry dropped", eff_addr, 32'd0, addr_fault, 1'b0);

        // R8: same register for base and index, top slot placement
        apply(1, 3'd7, 1, 3'd7, 2'd1, 2'd0, 32'd0);
        chk("R8 same reg", eff_addr, 32'h00C0_0000, addr_fault, 1'b0);

        // R1: random registers and encodings
        for (int n = 0; n < 300; n++) begin
            logic bv, iv;
            logic [2:0] bs, is;
            logic [1:0] sc, ds;
            logic [31:0] d;
            for (int k = 0; k < 8; k++) regs[k] = $urandom;
            bv = 1'($urandom); iv = 1'($urandom);
            bs = 3'($urandom); is = 3'($urandom);
            sc = 2'($urandom); ds = 2'($urandom); d = $urandom;
            apply(bv, bs, iv, is, sc, ds, d);
            chk("R1 random", eff_addr, ref_addr(bv, bs, iv, is, sc, ds, d),
                addr_fault, iv && is == 3'd4);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule